// File: doc/BRIEF.md
# Rotating Framebuffer DMA Parameter Calculator

This block turns a framebuffer description into the programming values for a two-dimensional DMA channel that walks the frame in a chosen display orientation. The description is a base address, the visible width and height in pixels, a virtual line width, horizontal and vertical scale factors, a rotation in degrees (0, 90, 180 or 270), a mirror flag and an element size code. From these it produces the first and last byte address of the walk, the element count per frame line, the frame count, and two signed strides: one applied between elements and one applied between frame lines.

A one-cycle start pulse loads the inputs. The block then validates them, computes six pixel offsets one per cycle, and derives the final values. A one-cycle done pulse marks completion. Invalid inputs produce an error flag together with done, and the previous results stay as they were. A flag also reports whether the walk needs double-indexed addressing or is a plain linear scan.

Pixel (x,y) sits at byte address base + (y·vw·ys + x·xs)·es, computed modulo 2^32. Strides equal the address of the destination pixel minus the address of the source pixel, minus es, plus one, taken as 32-bit two's complement. Width and height are assumed to be at least 1.

Top module: `fbrot_dma_calc`

## Requirements
- R1: After reset all result outputs are zero, and busy_o, done_o and err_o are low.
- R2: dtype_i selects the element size es: code 0 gives 1 byte, code 1 gives 2 bytes, code 2 gives 4 bytes. Code 3 is an error.
- R3: A vwidth_i of 0 is replaced by width_i. An xscale_i or yscale_i of 0 is replaced by 1.
- R4: The start and end addresses are the pixel addresses (formula above) of the chosen corner pixels, wrapping modulo 2^32. Here w and h are the visible width and height.
- R5: At 0 degrees, start is (0,0) and end is (w-1,h-1); the element stride runs (0,0)->(1,0) and the frame stride (w-1,0)->(0,1). At 180 degrees, start is (w-1,h-1) and end is (0,0); the element stride runs (1,0)->(0,0) and the frame stride (0,1)->(w-1,0). Both have element count w and frame count h.
- R6: At 90 degrees, start is (0,h-1) and end is (w-1,0); the element stride runs (0,1)->(0,0) and the frame stride (0,0)->(1,h-1). At 270 degrees, start is (w-1,0) and end is (0,h-1); the element stride runs (0,0)->(0,1) and the frame stride (1,h-1)->(0,0). Both have element count h and frame count w.
- R7: With mirror_i set, the walk becomes:
  - 0 degrees: start (w-1,0), end (0,h-1); element stride (1,0)->(0,0); frame stride (0,0)->(w-1,1).
  - 90 degrees: start (w-1,h-1), end (0,0); element stride (0,1)->(0,0); frame stride (1,0)->(0,h-1).
  - 180 degrees: start (0,h-1), end (w-1,0); element stride (0,0)->(1,0); frame stride (w-1,1)->(0,0).
  - 270 degrees: start (0,0), end (w-1,h-1); element stride (0,0)->(0,1); frame stride (0,h-1)->(1,0).
- R8: Each stride is addr(destination) - addr(source) - es + 1, as 32-bit two's complement.
- R9: dbl_idx_o is 1 when the raw rotation, mirror, vwidth, xscale or yscale is nonzero, and 0 otherwise. When it is 0, both strides equal 1.
- R10: Any of the following is an error: a rotation other than 0, 90, 180 or 270; dtype_i equal to 3; a nonzero vwidth_i smaller than width_i. An error raises err_o with done_o and leaves every result output unchanged.
- R11: A start_i pulse is accepted only while busy_o is low. busy_o is high from the next cycle until completion. done_o is a one-cycle pulse at most 10 cycles after start, and it never coincides with busy_o. A start_i pulse while busy_o is high is ignored.
- R12: err_o holds until the next accepted start and is low while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, loads all geometry inputs |
| base_i | input | 32 | Framebuffer base byte address |
| width_i | input | 16 | Visible width in pixels |
| height_i | input | 16 | Visible height in pixels |
| vwidth_i | input | 16 | Virtual line width in pixels, 0 = visible width |
| xscale_i | input | 8 | Horizontal scale, 0 = 1 |
| yscale_i | input | 8 | Vertical scale, 0 = 1 |
| rot_deg_i | input | 9 | Rotation in degrees |
| mirror_i | input | 1 | Reverse horizontal direction |
| dtype_i | input | 2 | Element size code |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was invalid |
| start_addr_o | output | 32 | First byte address of the walk |
| end_addr_o | output | 32 | Last byte address of the walk |
| elem_cnt_o | output | 16 | Elements per frame line |
| frame_cnt_o | output | 16 | Number of frame lines |
| elem_idx_o | output | 32 | Signed element stride |
| frame_idx_o | output | 32 | Signed frame stride |
| dbl_idx_o | output | 1 | Double-indexed mode needed |

## Verification
The assertions check the handshake on every cycle:
- done is a single-cycle pulse and never overlaps busy;
- err stays low during a computation;
- result registers change only on a successful completion, so an error can never disturb them;
- whenever the plain-scan flag is reported, both strides are exactly 1.

The actual address and stride values for each of the eight rotation and mirror combinations, the defaulting of zero vwidth and scale, the modulo-2^32 wrap, and the dropping of a start pulse during a computation can only be shown by the bench's scenarios. The bench compares those values against an independent pixel address model.

// File: rtl/fbrot_pkg.sv
package fbrot_pkg;
  localparam int unsigned DIM_W   = 16;
  localparam int unsigned DEG_W   = 9;
  localparam int unsigned NUM_PTS = 6;  // start, end, e_src, e_dst, f_src, f_dst

  typedef logic [DIM_W-1:0] dim_t;
  typedef enum logic [1:0] {ROT_0, ROT_90, ROT_180, ROT_270} rot_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_CALC, ST_FIN} state_e;
  typedef struct packed {dim_t x; dim_t y;} pt_t;
  typedef pt_t [NUM_PTS-1:0] pts_t;

  function automatic pt_t mk(dim_t x, dim_t y);
    pt_t p;
    p.x = x;
    p.y = y;
    return p;
  endfunction

  // xm = w-1, ym = h-1
  function automatic pts_t pick_points(rot_e r, logic m, dim_t xm, dim_t ym);
    pts_t p;
    dim_t z;
    dim_t o;
    z = '0;
    o = dim_t'(1);
    unique case ({r, m})
      {ROT_0,   1'b0}: begin p[0]=mk(z,z);   p[1]=mk(xm,ym); p[2]=mk(z,z); p[3]=mk(o,z); p[4]=mk(xm,z); p[5]=mk(z,o);  end
      {ROT_0,   1'b1}: begin p[0]=mk(xm,z);  p[1]=mk(z,ym);  p[2]=mk(o,z); p[3]=mk(z,z); p[4]=mk(z,z);  p[5]=mk(xm,o); end
      {ROT_90,  1'b0}: begin p[0]=mk(z,ym);  p[1]=mk(xm,z);  p[2]=mk(z,o); p[3]=mk(z,z); p[4]=mk(z,z);  p[5]=mk(o,ym); end
      {ROT_90,  1'b1}: begin p[0]=mk(xm,ym); p[1]=mk(z,z);   p[2]=mk(z,o); p[3]=mk(z,z); p[4]=mk(o,z);  p[5]=mk(z,ym); end
      {ROT_180, 1'b0}: begin p[0]=mk(xm,ym); p[1]=mk(z,z);   p[2]=mk(o,z); p[3]=mk(z,z); p[4]=mk(z,o);  p[5]=mk(xm,z); end
      {ROT_180, 1'b1}: begin p[0]=mk(z,ym);  p[1]=mk(xm,z);  p[2]=mk(z,z); p[3]=mk(o,z); p[4]=mk(xm,o); p[5]=mk(z,z);  end
      {ROT_270, 1'b0}: begin p[0]=mk(xm,z);  p[1]=mk(z,ym);  p[2]=mk(z,z); p[3]=mk(z,o); p[4]=mk(o,ym); p[5]=mk(z,z);  end
      default:         begin p[0]=mk(z,z);   p[1]=mk(xm,ym); p[2]=mk(z,z); p[3]=mk(z,o); p[4]=mk(z,ym); p[5]=mk(o,z);  end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/fbrot_geom_chk.sv
module fbrot_geom_chk
  import fbrot_pkg::*;
#(
  parameter int unsigned SW = 8
) (
  input  dim_t             w_i,
  input  dim_t             vw_i,
  input  logic [SW-1:0]    xs_i,
  input  logic [SW-1:0]    ys_i,
  input  logic [DEG_W-1:0] rot_deg_i,
  input  logic             mirror_i,
  input  logic [1:0]       dtype_i,
  output dim_t             vw_eff_o,
  output logic [SW-1:0]    xs_eff_o,
  output logic [SW-1:0]    ys_eff_o,
  output logic [1:0]       es_sh_o,
  output rot_e             rot_o,
  output logic             dbl_o,
  output logic             err_o
);
  logic bad_rot, bad_dt, bad_vw;

  always_comb begin
    bad_rot = 1'b0;
    unique case (rot_deg_i)
      DEG_W'(0):   rot_o = ROT_0;
      DEG_W'(90):  rot_o = ROT_90;
      DEG_W'(180): rot_o = ROT_180;
      DEG_W'(270): rot_o = ROT_270;
      default: begin rot_o = ROT_0; bad_rot = 1'b1; end
    endcase
    bad_dt  = (dtype_i == 2'd3);
    es_sh_o = bad_dt ? 2'd0 : dtype_i;
    bad_vw  = (vw_i != '0) && (vw_i < w_i);
    vw_eff_o = (vw_i == '0) ? w_i : vw_i;
    xs_eff_o = (xs_i == '0) ? SW'(1) : xs_i;
    ys_eff_o = (ys_i == '0) ? SW'(1) : ys_i;
    dbl_o = (rot_deg_i != '0) || mirror_i || (vw_i != '0) || (xs_i != '0) || (ys_i != '0);
    err_o = bad_rot || bad_dt || bad_vw;
  end
endmodule

// File: rtl/fbrot_pix_offset.sv
module fbrot_pix_offset
  import fbrot_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 8
) (
  input  pt_t           pt_i,
  input  dim_t          vw_i,
  input  logic [SW-1:0] xs_i,
  input  logic [SW-1:0] ys_i,
  input  logic [1:0]    es_sh_i,
  output logic [AW-1:0] off_o
);
  logic [AW-1:0] row_part, col_part;

  always_comb begin
    row_part = AW'(pt_i.y) * AW'(vw_i) * AW'(ys_i);
    col_part = AW'(pt_i.x) * AW'(xs_i);
    off_o    = (row_part + col_part) << es_sh_i;
  end
endmodule

// File: rtl/fbrot_dma_calc.sv
module fbrot_dma_calc
  import fbrot_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic [DIM_W-1:0] vwidth_i,
  input  logic [SW-1:0]    xscale_i,
  input  logic [SW-1:0]    yscale_i,
  input  logic [DEG_W-1:0] rot_deg_i,
  input  logic             mirror_i,
  input  logic [1:0]       dtype_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [AW-1:0]    start_addr_o,
  output logic [AW-1:0]    end_addr_o,
  output logic [DIM_W-1:0] elem_cnt_o,
  output logic [DIM_W-1:0] frame_cnt_o,
  output logic [AW-1:0]    elem_idx_o,
  output logic [AW-1:0]    frame_idx_o,
  output logic             dbl_idx_o
);
  localparam int unsigned IDX_W = $clog2(NUM_PTS);

  state_e             state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [AW-1:0]      base_q;
  dim_t               w_q, h_q, vw_q;
  logic [SW-1:0]      xs_q, ys_q;
  logic [DEG_W-1:0]   rot_q;
  logic               mir_q;
  logic [1:0]         dt_q;
  logic [AW-1:0]      off_q [NUM_PTS];

  dim_t          g_vw;
  logic [SW-1:0] g_xs, g_ys;
  logic [1:0]    g_sh;
  rot_e          g_rot;
  logic          g_dbl, g_err;
  pts_t          pts;
  logic [AW-1:0] cur_off, esize;

  fbrot_geom_chk #(.SW(SW)) u_chk (
    .w_i(w_q), .vw_i(vw_q), .xs_i(xs_q), .ys_i(ys_q), .rot_deg_i(rot_q),
    .mirror_i(mir_q), .dtype_i(dt_q), .vw_eff_o(g_vw), .xs_eff_o(g_xs),
    .ys_eff_o(g_ys), .es_sh_o(g_sh), .rot_o(g_rot), .dbl_o(g_dbl), .err_o(g_err)
  );

  assign pts   = pick_points(g_rot, mir_q, w_q - dim_t'(1), h_q - dim_t'(1));
  assign esize = AW'(1) << g_sh;

  fbrot_pix_offset #(.AW(AW), .SW(SW)) u_off (
    .pt_i(pts[idx_q]), .vw_i(g_vw), .xs_i(g_xs), .ys_i(g_ys),
    .es_sh_i(g_sh), .off_o(cur_off)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0; w_q <= '0; h_q <= '0; vw_q <= '0;
      xs_q    <= '0; ys_q <= '0; rot_q <= '0; mir_q <= 1'b0; dt_q <= '0;
      for (int i = 0; i < NUM_PTS; i++) off_q[i] <= '0;
      done_o <= 1'b0; err_o <= 1'b0;
      start_addr_o <= '0; end_addr_o <= '0;
      elem_cnt_o <= '0; frame_cnt_o <= '0;
      elem_idx_o <= '0; frame_idx_o <= '0; dbl_idx_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q <= base_i; w_q <= width_i; h_q <= height_i; vw_q <= vwidth_i;
          xs_q <= xscale_i; ys_q <= yscale_i; rot_q <= rot_deg_i;
          mir_q <= mirror_i; dt_q <= dtype_i;
          err_o <= 1'b0;
          state_q <= ST_CHK;
        end
        ST_CHK: if (g_err) begin
          err_o <= 1'b1; done_o <= 1'b1; state_q <= ST_IDLE;
        end else begin
          idx_q <= '0; state_q <= ST_CALC;
        end
        ST_CALC: begin
          off_q[idx_q] <= cur_off;
          if (idx_q == IDX_W'(NUM_PTS - 1)) state_q <= ST_FIN;
          else idx_q <= idx_q + IDX_W'(1);
        end
        default: begin
          start_addr_o <= base_q + off_q[0];
          end_addr_o   <= base_q + off_q[1];
          elem_idx_o   <= off_q[3] - off_q[2] - esize + AW'(1);
          frame_idx_o  <= off_q[5] - off_q[4] - esize + AW'(1);
          elem_cnt_o   <= (g_rot == ROT_0 || g_rot == ROT_180) ? w_q : h_q;
          frame_cnt_o  <= (g_rot == ROT_0 || g_rot == ROT_180) ? h_q : w_q;
          dbl_idx_o    <= g_dbl;
          done_o <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R12
  err_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !err_o);
  // R10
  hold_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(start_addr_o) && $stable(end_addr_o) && $stable(elem_idx_o) && $stable(frame_idx_o))
      |-> (done_o && !err_o));
  // R9
  plain_stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && !dbl_idx_o) |-> (elem_idx_o == AW'(1) && frame_idx_o == AW'(1)));
endmodule

// File: tb/fbrot_dma_calc_bench.sv
module fbrot_dma_calc_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] width = '0, height = '0, vwidth = '0;
  logic [7:0]  xscale = '0, yscale = '0;
  logic [8:0]  rot_deg = '0;
  logic        mirror = 1'b0;
  logic [1:0]  dtype = '0;
  logic busy, done, err, dbl;
  logic [31:0] sa, ea, ei, fi;
  logic [15:0] ec, fc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbrot_dma_calc u_fbrot_dma_calc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .width_i(width),
    .height_i(height), .vwidth_i(vwidth), .xscale_i(xscale), .yscale_i(yscale),
    .rot_deg_i(rot_deg), .mirror_i(mirror), .dtype_i(dtype), .busy_o(busy),
    .done_o(done), .err_o(err), .start_addr_o(sa), .end_addr_o(ea),
    .elem_cnt_o(ec), .frame_cnt_o(fc), .elem_idx_o(ei), .frame_idx_o(fi), .dbl_idx_o(dbl)
  );

  typedef struct {
    bit err; logic [31:0] sa, ea, ei, fi; logic [15:0] ec, fc; bit dbl; string tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int checks = 0, errors = 0;

  function automatic logic [31:0] pa(logic [31:0] b, logic [31:0] x, logic [31:0] y,
                                     logic [31:0] vw, logic [31:0] xs, logic [31:0] ys,
                                     logic [31:0] es);
    return b + (y * vw * ys + x * xs) * es;
  endfunction

  task automatic run_case(input logic [31:0] b, input int w, input int h, input int vw,
                          input int xs, input int ys, input int rd, input bit m,
                          input int dt, input bit glitch, input string tag);
    exp_t e;
    logic [31:0] vwe, xse, yse, es, xm, ym;
    logic [31:0] c [12];
    int n;
    vwe = (vw == 0) ? w : vw;
    xse = (xs == 0) ? 1 : xs;
    yse = (ys == 0) ? 1 : ys;
    es  = (dt == 0) ? 1 : (dt == 1) ? 2 : 4;
    xm = w - 1; ym = h - 1;
    e = last;
    e.tag = tag;
    if (dt == 3 || !(rd == 0 || rd == 90 || rd == 180 || rd == 270) || (vw != 0 && vw < w)) begin
      e.err = 1'b1;
    end else begin
      // start(x,y), end(x,y), e_src, e_dst, f_src, f_dst
      case ({rd[8:0], m})
        {9'd0, 1'b0}:   c = '{0,0,  xm,ym, 0,0, 1,0, xm,0, 0,1};
        {9'd0, 1'b1}:   c = '{xm,0, 0,ym,  1,0, 0,0, 0,0,  xm,1};
        {9'd90, 1'b0}:  c = '{0,ym, xm,0,  0,1, 0,0, 0,0,  1,ym};
        {9'd90, 1'b1}:  c = '{xm,ym,0,0,   0,1, 0,0, 1,0,  0,ym};
        {9'd180, 1'b0}: c = '{xm,ym,0,0,   1,0, 0,0, 0,1,  xm,0};
        {9'd180, 1'b1}: c = '{0,ym, xm,0,  0,0, 1,0, xm,1, 0,0};
        {9'd270, 1'b0}: c = '{xm,0, 0,ym,  0,0, 0,1, 1,ym, 0,0};
        default:        c = '{0,0,  xm,ym, 0,0, 0,1, 0,ym, 1,0};
      endcase
      e.err = 1'b0;
      e.sa = pa(b, c[0], c[1], vwe, xse, yse, es);
      e.ea = pa(b, c[2], c[3], vwe, xse, yse, es);
      e.ei = pa(b, c[6], c[7], vwe, xse, yse, es) - pa(b, c[4], c[5], vwe, xse, yse, es) - es + 1;
      e.fi = pa(b, c[10], c[11], vwe, xse, yse, es) - pa(b, c[8], c[9], vwe, xse, yse, es) - es + 1;
      e.ec = (rd == 0 || rd == 180) ? w[15:0] : h[15:0];
      e.fc = (rd == 0 || rd == 180) ? h[15:0] : w[15:0];
      e.dbl = (rd != 0) || m || (vw != 0) || (xs != 0) || (ys != 0);
      last = e;
      last.err = 1'b0;
    end
    q.push_back(e);
    @(negedge clk);
    base = b; width = w[15:0]; height = h[15:0]; vwidth = vw[15:0];
    xscale = xs[7:0]; yscale = ys[7:0]; rot_deg = rd[8:0]; mirror = m; dtype = dt[1:0];
    start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (glitch && n == 2) begin
        checks++;
        if (!busy) begin errors++; $display("FAIL R11 busy low during computation: act %0b exp 1", busy); end
        base = ~b; rot_deg = 9'd90; mirror = ~m; start = 1'b1;
      end else start = 1'b0;
    end while (!done && n < 40);
    checks++;
    if (!done || n > 10) begin
      errors++;
      $display("FAIL R11 %s latency: act %0d cycles done=%0b exp <=10", tag, n, done);
    end
    @(negedge clk);
  endtask

  // Monitor: compare each completion against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected done: act done=1 exp none pending");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (err !== e.err || sa !== e.sa || ea !== e.ea || ei !== e.ei || fi !== e.fi ||
              ec !== e.ec || fc !== e.fc || dbl !== e.dbl) begin
            errors++;
            $display("FAIL %s act err=%0b sa=%h ea=%h ei=%h fi=%h ec=%0d fc=%0d dbl=%0b exp err=%0b sa=%h ea=%h ei=%h fi=%h ec=%0d fc=%0d dbl=%0b",
                     e.tag, err, sa, ea, ei, fi, ec, fc, dbl,
                     e.err, e.sa, e.ea, e.ei, e.fi, e.ec, e.fc, e.dbl);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    last = '{err: 1'b0, sa: '0, ea: '0, ei: '0, fi: '0, ec: '0, fc: '0, dbl: 1'b0, tag: ""};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (busy || done || err || sa != 0 || ea != 0 || ei != 0 || fi != 0 || ec != 0 || fc != 0 || dbl) begin
      errors++;
      $display("FAIL R1 reset: act busy=%0b done=%0b err=%0b sa=%h exp all zero", busy, done, err, sa);
    end
    // R5 R9 R2 R3: plain scan, 16-bit, defaults
    run_case(32'h1000_0000, 320, 240, 0, 0, 0, 0,   1'b0, 1, 1'b0, "R5 R9 rot0 plain");
    run_case(32'h2000_0000, 7, 5, 0, 0, 0, 0,       1'b1, 0, 1'b0, "R7 rot0 mirror 8bit");
    run_case(32'h0004_0000, 10, 6, 16, 2, 3, 90,    1'b0, 2, 1'b0, "R6 R2 rot90 32bit scaled");
    run_case(32'h0004_0000, 10, 6, 16, 0, 0, 90,    1'b1, 1, 1'b0, "R7 rot90 mirror");
    run_case(32'h0100_0000, 9, 4, 12, 0, 0, 180,    1'b0, 1, 1'b0, "R5 rot180");
    run_case(32'h0100_0000, 9, 4, 0, 1, 1, 180,     1'b1, 0, 1'b0, "R7 rot180 mirror");
    run_case(32'h0200_0000, 11, 3, 0, 0, 2, 270,    1'b0, 2, 1'b0, "R6 rot270");
    run_case(32'h0200_0000, 11, 3, 20, 3, 0, 270,   1'b1, 1, 1'b0, "R7 rot270 mirror");
    run_case(32'h0300_0000, 8, 8, 0, 2, 0, 0,       1'b0, 0, 1'b0, "R9 R3 xscale only");
    run_case(32'hFFFF_FF00, 100, 50, 0, 0, 0, 0,    1'b0, 2, 1'b0, "R4 R8 address wrap");
    // R10 errors keep results
    run_case(32'h5000_0000, 4, 4, 0, 0, 0, 0,       1'b0, 3, 1'b0, "R10 R2 bad dtype");
    run_case(32'h5000_0000, 4, 4, 0, 0, 0, 45,      1'b0, 1, 1'b0, "R10 bad rotation");
    run_case(32'h5000_0000, 16, 4, 8, 0, 0, 0,      1'b0, 1, 1'b0, "R10 vwidth below width");
    // R12 error cleared by next good request
    run_case(32'h0600_0000, 5, 3, 5, 0, 0, 90,      1'b0, 0, 1'b0, "R12 R6 recover after error");
    // R11 start while busy ignored
    run_case(32'h0700_0000, 6, 2, 0, 0, 0, 180,     1'b0, 1, 1'b1, "R11 start while busy ignored");
    repeat (5) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending results: act %0d exp 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule